// File: doc/BRIEF.md
# Converter Start-Up Mute Sequencer

This block governs the start-up quieting of a stereo audio converter pair: a two-channel analog-to-digital path and a two-channel digital-to-analog path. It watches three power-enable bits (left ADC, right ADC, DAC) in the system clock domain. When a path is switched on while the opposite path is still off, the block holds that path's data at two's-complement zero for a fixed number of sample periods, counted on a one-cycle sample-rate strobe, and shows a busy flag for that path meanwhile. When the opposite path is already on, the newly enabled path is let through at once.

Two data muxes sit in the path: one on the stereo words coming out of the ADC, one on the stereo words going into the DAC. A path that is disabled, still initializing, or was cut off mid-initialization presents zero. An active-low power-down input clears every control register and stops any count in progress. The length of the initialization is the parameter `INIT_LEN` (1059 sample periods by default) and the word width is `DATA_W`.

Top module: `conv_init_seq`

## Requirements
- R1: While `pd_n` is low, both busy flags are 0 and all four data outputs are zero; this holds in the first cycle after `pd_n` returns high with all enables low.
- R2: When `en_adc_l` or `en_adc_r` goes from 0 to 1 while `en_dac` is 0, `adc_busy` is 1 after the next rising clock edge and both ADC outputs read zero.
- R3: When `en_dac` goes from 0 to 1 while both ADC enables are 0, `dac_busy` is 1 after the next rising clock edge and both DAC outputs read zero.
- R4: A busy flag stays 1 through the first `INIT_LEN`-1 strobes after it rose and falls at the clock edge that samples the `INIT_LEN`-th strobe.
- R5: Once a path is released and enabled, its outputs equal its inputs bit for bit.
- R6: An enable rise for one path while the other path has any enable at 1 releases the path at once: its busy flag stays 0 and its data passes after the next clock edge.
- R7: If all enables of a running path drop to 0, its busy flag falls at the next edge, its outputs stay zero, and the next enable rise starts a fresh count of `INIT_LEN` strobes.
- R8: A path with all its enables at 0 outputs zero.
- R9: When an ADC enable and the DAC enable rise in the same cycle, neither path initializes and both pass data after the next edge.
- R10: Pulling `pd_n` low during a count clears the busy flag and mutes the path at once; enables still high when `pd_n` returns count as new rises.
- R11: Raising the second ADC channel enable while the ADC path is already released does not restart initialization.
- R12: The two busy flags are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pd_n | input | 1 | Active-low power-down, asynchronous reset of all control state |
| fs_stb | input | 1 | One-cycle strobe, once per sample period |
| en_adc_l | input | 1 | Left ADC power enable |
| en_adc_r | input | 1 | Right ADC power enable |
| en_dac | input | 1 | DAC power enable |
| adc_l_in | input | DATA_W | Left word from the ADC |
| adc_r_in | input | DATA_W | Right word from the ADC |
| dac_l_in | input | DATA_W | Left word toward the DAC |
| dac_r_in | input | DATA_W | Right word toward the DAC |
| adc_l_out | output | DATA_W | Left ADC word after muting |
| adc_r_out | output | DATA_W | Right ADC word after muting |
| dac_l_out | output | DATA_W | Left DAC word after muting |
| dac_r_out | output | DATA_W | Right DAC word after muting |
| adc_busy | output | 1 | ADC path initialization running |
| dac_busy | output | 1 | DAC path initialization running |

## Verification
The bench builds the block with `INIT_LEN` = 6 and `DATA_W` = 16, so a full initialization takes a handful of strobes and every count boundary (the last strobe before release, the releasing strobe, an abort partway through and the full recount after it) is reached many times within a short run. The 16-bit words include a negative value and full-scale values, so any stuck or partial bit in the muxes shows in both polarities.

// File: rtl/conv_init_pkg.sv
package conv_init_pkg;

   typedef enum logic [1:0] {
      PATH_HOLD = 2'b00,
      PATH_RUN  = 2'b01,
      PATH_PASS = 2'b10
   } path_state_t;

   localparam int unsigned NUM_STEREO = 2;

   function automatic int unsigned cnt_width(input int unsigned len);
      return (len < 2) ? 1 : $clog2(len);
   endfunction

endpackage

// File: rtl/conv_edge_det.sv
module conv_edge_det #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);

   if (N < 1) begin : g_bad_n
      $error("conv_edge_det: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q <= 1'b0;
         else        lvl_q <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~lvl_q;
   end

endmodule

// File: rtl/conv_path_seq.sv
module conv_path_seq
   import conv_init_pkg::*;
#(
   parameter int unsigned INIT_LEN = 1059
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_any,
   input  logic rise,
   input  logic other_on,
   input  logic stb,
   output logic busy,
   output logic mute
);

   localparam int unsigned CNT_W = cnt_width(INIT_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_LEN - 1);

   if (INIT_LEN < 2) begin : g_bad_len
      $error("conv_path_seq: INIT_LEN must be at least 2");
   end

   path_state_t      state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         PATH_HOLD: begin
            cnt_d = '0;
            if (rise) state_d = other_on ? PATH_PASS : PATH_RUN;
         end
         PATH_RUN: begin
            if (!en_any) begin
               state_d = PATH_HOLD;
               cnt_d   = '0;
            end else if (stb) begin
               if (cnt_q == LAST) begin
                  state_d = PATH_PASS;
                  cnt_d   = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         PATH_PASS: begin
            cnt_d = '0;
            if (!en_any) state_d = PATH_HOLD;
         end
         default: begin
            state_d = PATH_HOLD;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PATH_HOLD;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign busy = (state_q == PATH_RUN);
   assign mute = (state_q != PATH_PASS);

endmodule

// File: rtl/conv_zero_mux.sv
module conv_zero_mux #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NCH    = 2
) (
   input  logic                        mute,
   input  logic [NCH-1:0][DATA_W-1:0]  din,
   output logic [NCH-1:0][DATA_W-1:0]  dout
);

   if (DATA_W < 2) begin : g_bad_w
      $error("conv_zero_mux: DATA_W must be at least 2");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign dout[c] = mute ? '0 : din[c];
   end

endmodule

// File: rtl/conv_init_seq.sv
module conv_init_seq
   import conv_init_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned INIT_LEN = 1059
) (
   input  logic              clk,
   input  logic              pd_n,
   input  logic              fs_stb,
   input  logic              en_adc_l,
   input  logic              en_adc_r,
   input  logic              en_dac,
   input  logic [DATA_W-1:0] adc_l_in,
   input  logic [DATA_W-1:0] adc_r_in,
   input  logic [DATA_W-1:0] dac_l_in,
   input  logic [DATA_W-1:0] dac_r_in,
   output logic [DATA_W-1:0] adc_l_out,
   output logic [DATA_W-1:0] adc_r_out,
   output logic [DATA_W-1:0] dac_l_out,
   output logic [DATA_W-1:0] dac_r_out,
   output logic              adc_busy,
   output logic              dac_busy
);

   localparam int unsigned N_EN = 3;

   logic [N_EN-1:0] en_vec, en_rise;
   logic            adc_on, adc_rise, adc_mute, dac_mute;
   logic [NUM_STEREO-1:0][DATA_W-1:0] adc_in_v, adc_out_v, dac_in_v, dac_out_v;

   assign en_vec   = {en_dac, en_adc_r, en_adc_l};
   assign adc_on   = en_adc_l | en_adc_r;
   assign adc_rise = en_rise[0] | en_rise[1];

   conv_edge_det #(.N(N_EN)) edge_i (
      .clk  (clk),
      .rst_n(pd_n),
      .lvl  (en_vec),
      .rise (en_rise)
   );

   conv_path_seq #(.INIT_LEN(INIT_LEN)) adc_seq_i (
      .clk     (clk),
      .rst_n   (pd_n),
      .en_any  (adc_on),
      .rise    (adc_rise),
      .other_on(en_dac),
      .stb     (fs_stb),
      .busy    (adc_busy),
      .mute    (adc_mute)
   );

   conv_path_seq #(.INIT_LEN(INIT_LEN)) dac_seq_i (
      .clk     (clk),
      .rst_n   (pd_n),
      .en_any  (en_dac),
      .rise    (en_rise[2]),
      .other_on(adc_on),
      .stb     (fs_stb),
      .busy    (dac_busy),
      .mute    (dac_mute)
   );

   assign adc_in_v = {adc_r_in, adc_l_in};
   assign dac_in_v = {dac_r_in, dac_l_in};

   conv_zero_mux #(.DATA_W(DATA_W), .NCH(NUM_STEREO)) adc_mux_i (
      .mute(adc_mute),
      .din (adc_in_v),
      .dout(adc_out_v)
   );

   conv_zero_mux #(.DATA_W(DATA_W), .NCH(NUM_STEREO)) dac_mux_i (
      .mute(dac_mute),
      .din (dac_in_v),
      .dout(dac_out_v)
   );

   assign adc_l_out = adc_out_v[0];
   assign adc_r_out = adc_out_v[1];
   assign dac_l_out = dac_out_v[0];
   assign dac_r_out = dac_out_v[1];

endmodule

// File: rtl/conv_init_seq_chk.sv
module conv_init_seq_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              pd_n,
   input logic              fs_stb,
   input logic              en_adc_l,
   input logic              en_adc_r,
   input logic              en_dac,
   input logic [DATA_W-1:0] adc_l_out,
   input logic [DATA_W-1:0] adc_r_out,
   input logic [DATA_W-1:0] dac_l_out,
   input logic [DATA_W-1:0] dac_r_out,
   input logic              adc_busy,
   input logic              dac_busy
);

   assert_idle_after_pd_R1: assert property (@(posedge clk) disable iff (!pd_n)
      $rose(pd_n) |-> (!adc_busy && !dac_busy));

   assert_adc_busy_zero_R2: assert property (@(posedge clk) disable iff (!pd_n)
      adc_busy |-> (adc_l_out == '0 && adc_r_out == '0));

   assert_dac_busy_zero_R3: assert property (@(posedge clk) disable iff (!pd_n)
      dac_busy |-> (dac_l_out == '0 && dac_r_out == '0));

   assert_adc_start_dac_off_R6: assert property (@(posedge clk) disable iff (!pd_n)
      $rose(adc_busy) |-> $past(!en_dac));

   assert_dac_start_adc_off_R6: assert property (@(posedge clk) disable iff (!pd_n)
      $rose(dac_busy) |-> $past(!en_adc_l && !en_adc_r));

   assert_adc_end_cause_R4: assert property (@(posedge clk) disable iff (!pd_n)
      $fell(adc_busy) |-> ($past(fs_stb) || $past(!en_adc_l && !en_adc_r)));

   assert_dac_end_cause_R4: assert property (@(posedge clk) disable iff (!pd_n)
      $fell(dac_busy) |-> ($past(fs_stb) || $past(!en_dac)));

   assert_adc_off_zero_R8: assert property (@(posedge clk) disable iff (!pd_n)
      (!en_adc_l && !en_adc_r) |=> (adc_l_out == '0 && adc_r_out == '0));

   assert_dac_off_zero_R8: assert property (@(posedge clk) disable iff (!pd_n)
      !en_dac |=> (dac_l_out == '0 && dac_r_out == '0));

   assert_never_both_busy_R12: assert property (@(posedge clk) disable iff (!pd_n)
      !(adc_busy && dac_busy));

endmodule

bind conv_init_seq conv_init_seq_chk #(.DATA_W(DATA_W)) chk_i (
   .clk      (clk),
   .pd_n     (pd_n),
   .fs_stb   (fs_stb),
   .en_adc_l (en_adc_l),
   .en_adc_r (en_adc_r),
   .en_dac   (en_dac),
   .adc_l_out(adc_l_out),
   .adc_r_out(adc_r_out),
   .dac_l_out(dac_l_out),
   .dac_r_out(dac_r_out),
   .adc_busy (adc_busy),
   .dac_busy (dac_busy)
);

// File: tb/conv_init_seq_tb.sv
module conv_init_seq_tb_top;

   localparam int unsigned DW  = 16;
   localparam int unsigned LEN = 6;

   logic          clk = 1'b0;
   logic          pd_n = 1'b0;
   logic          fs_stb = 1'b0;
   logic          en_adc_l = 1'b0, en_adc_r = 1'b0, en_dac = 1'b0;
   logic [DW-1:0] adc_l_in = 16'h1234, adc_r_in = 16'hA5A5;
   logic [DW-1:0] dac_l_in = 16'h7FFF, dac_r_in = 16'h8001;
   logic [DW-1:0] adc_l_out, adc_r_out, dac_l_out, dac_r_out;
   logic          adc_busy, dac_busy;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   conv_init_seq #(.DATA_W(DW), .INIT_LEN(LEN)) dut_i (
      .clk(clk), .pd_n(pd_n), .fs_stb(fs_stb),
      .en_adc_l(en_adc_l), .en_adc_r(en_adc_r), .en_dac(en_dac),
      .adc_l_in(adc_l_in), .adc_r_in(adc_r_in),
      .dac_l_in(dac_l_in), .dac_r_in(dac_r_in),
      .adc_l_out(adc_l_out), .adc_r_out(adc_r_out),
      .dac_l_out(dac_l_out), .dac_r_out(dac_r_out),
      .adc_busy(adc_busy), .dac_busy(dac_busy)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic strobe(input int n);
      for (int i = 0; i < n; i++) begin
         fs_stb = 1'b1; tick();
         fs_stb = 1'b0; tick();
      end
   endtask

   task automatic check_adc(input string tag, input bit pass);
      check({tag, " adc_l"}, adc_l_out, pass ? adc_l_in : '0);
      check({tag, " adc_r"}, adc_r_out, pass ? adc_r_in : '0);
   endtask

   task automatic check_dac(input string tag, input bit pass);
      check({tag, " dac_l"}, dac_l_out, pass ? dac_l_in : '0);
      check({tag, " dac_r"}, dac_r_out, pass ? dac_r_in : '0);
   endtask

   task automatic do_reset();
      pd_n = 1'b0; en_adc_l = 0; en_adc_r = 0; en_dac = 0; fs_stb = 0;
      tick(); tick();
      pd_n = 1'b1; tick();
   endtask

   task automatic t_reset();
      pd_n = 1'b0; tick(); tick();
      check("R1 adc_busy in pd", adc_busy, 0);
      check("R1 dac_busy in pd", dac_busy, 0);
      check_adc("R1 pd", 0);
      check_dac("R1 pd", 0);
      pd_n = 1'b1; tick();
      check("R1 adc_busy after pd", adc_busy, 0);
      check_adc("R1 after pd", 0);
      check_dac("R8 dac off", 0);
   endtask

   task automatic t_adc_init();
      en_adc_l = 1; tick();
      check("R2 adc_busy", adc_busy, 1);
      check_adc("R2 running", 0);
      strobe(LEN - 1);
      check("R4 adc_busy before last", adc_busy, 1);
      check_adc("R4 before last", 0);
      strobe(1);
      check("R4 adc_busy released", adc_busy, 0);
      check_adc("R5 adc pass", 1);
      check_dac("R8 dac still off", 0);
   endtask

   task automatic t_dac_skip();
      en_dac = 1; tick();
      check("R6 dac_busy skip", dac_busy, 0);
      check_dac("R6 dac pass", 1);
      en_adc_r = 1; tick();
      check("R11 adc_busy no restart", adc_busy, 0);
      check_adc("R11 adc pass", 1);
   endtask

   task automatic t_dac_init();
      en_dac = 1; tick();
      check("R3 dac_busy", dac_busy, 1);
      check_dac("R3 running", 0);
      strobe(LEN - 1);
      check("R4 dac_busy before last", dac_busy, 1);
      strobe(1);
      check("R4 dac_busy released", dac_busy, 0);
      check_dac("R5 dac pass", 1);
      en_adc_r = 1; tick();
      check("R6 adc_busy skip", adc_busy, 0);
      check_adc("R6 adc pass", 1);
   endtask

   task automatic t_abort();
      en_dac = 1; tick();
      strobe(3);
      check("R7 dac_busy mid", dac_busy, 1);
      en_dac = 0; tick();
      check("R7 dac_busy aborted", dac_busy, 0);
      check_dac("R7 aborted", 0);
      strobe(3);
      check_dac("R7 stays zero", 0);
      en_dac = 1; tick();
      check("R7 dac_busy restart", dac_busy, 1);
      strobe(LEN - 1);
      check("R7 fresh count not done", dac_busy, 1);
      check_dac("R7 fresh count zero", 0);
      strobe(1);
      check("R7 fresh count done", dac_busy, 0);
      check_dac("R7 pass after recount", 1);
   endtask

   task automatic t_simul();
      en_adc_l = 1; en_dac = 1; tick();
      check("R9 adc_busy", adc_busy, 0);
      check("R9 dac_busy", dac_busy, 0);
      check_adc("R9 adc pass", 1);
      check_dac("R9 dac pass", 1);
   endtask

   task automatic t_pd_mid();
      en_adc_l = 1; tick();
      strobe(2);
      check("R10 adc_busy before pd", adc_busy, 1);
      pd_n = 0; #1;
      check("R10 adc_busy in pd", adc_busy, 0);
      check_adc("R10 muted in pd", 0);
      tick(); pd_n = 1; tick();
      check("R10 restart after pd", adc_busy, 1);
      strobe(LEN);
      check("R10 released after full count", adc_busy, 0);
      check_adc("R10 pass", 1);
   endtask

   initial begin
      tick();
      t_reset();
      t_adc_init();
      t_dac_skip();
      do_reset();
      t_dac_init();
      do_reset();
      t_abort();
      do_reset();
      t_simul();
      do_reset();
      t_pd_mid();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule